// File: doc/BRIEF.md
# Teletype-Style Keyboard and Printer Transfer Unit

This unit sits beside a small 12-bit processor and executes its input/output transfer instructions for two character devices: a keyboard that delivers 8-bit codes and a printer that takes 8-bit codes. Each device keeps a ready bit and an 8-bit character holding register. When the processor presents an instruction, the unit answers in the same cycle. It returns a replacement accumulator value with a write enable, and a request to skip the next instruction. The ready bits and holding registers change at the following clock edge.

The instruction word has three fields. The top three bits carry the transfer opcode, octal 6. The middle six bits carry a device number: octal 03 is the keyboard and octal 04 is the printer. The low three bits are a function mask whose bits combine freely. Bit 0 requests a skip when the ready bit is set. Bit 1 clears the ready bit, and for the keyboard it also clears the accumulator. Bit 2 moves a character. For the keyboard, a function value of zero clears the ready bit without asking for a new key.

Keyboard characters arrive on a valid/ready pair. `kbd_ready` is the inverse of the keyboard ready bit. A code is taken only in a cycle where both `kbd_valid` and `kbd_ready` are high. A code offered while the ready bit is set is not taken and has no effect, so the source must hold it or drop it. Whenever the keyboard ready bit is cleared with function bit 1, `kbd_req` pulses to ask the source for the next key. The printer side has no back-pressure. Each start pulse presents a new code, and the printer reports completion with a one-cycle `prn_done`. An interrupt request is raised while interrupts are enabled and either ready bit is set.

Top module: `iot_tty_ctrl`

## Requirements
- R1: After reset both ready bits are 0, `kbd_ready` is 1, and `irq`, `skip`, `ac_we`, `kbd_req` and `prn_start` are 0.
- R2: The unit acts only on a cycle with `iot_valid` high, opcode field `instr[11:9]` equal to 6, and device field `instr[8:3]` equal to 3 (keyboard) or 4 (printer). Any other cycle leaves `ac_we`, `skip` and `kbd_req` low and changes no ready bit or holding register.
- R3: Function bit 0 (`instr[0]`) raises `skip` in the same cycle when the addressed device's ready bit is set. The test uses the ready bit as it stood before any clear in the same instruction.
- R4: Keyboard function 0 clears the keyboard ready bit. It does not pulse `kbd_req` and does not write the accumulator.
- R5: Keyboard function bit 1 (`instr[1]`) clears the keyboard ready bit, pulses `kbd_req` in the same cycle, and raises `ac_we` with a cleared accumulator.
- R6: Keyboard function bit 2 (`instr[2]`) raises `ac_we`. `ac_out` is the keyboard character zero-extended to 12 bits and ORed into `ac_in`, or into zero when bit 1 is also set.
- R7: A code with `kbd_valid` and `kbd_ready` both high is latched and sets the keyboard ready bit at the next edge, even if a clear arrives in the same cycle. A code offered while the ready bit is set leaves the held character unchanged.
- R8: Printer function bit 2 latches `ac_in[7:0]`. In the next cycle it drives that value on `prn_char` with a one-cycle `prn_start` pulse, and it leaves the printer ready bit unchanged.
- R9: Printer function bit 1 clears the printer ready bit. `prn_done` sets it and wins over a clear in the same cycle. Printer functions never write the accumulator.
- R10: `irq` is high exactly when `intr_en` is high and at least one ready bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_valid | input | 1 | Instruction present this cycle |
| instr | input | 12 | Transfer instruction word |
| ac_in | input | 12 | Current accumulator |
| ac_out | output | 12 | New accumulator value |
| ac_we | output | 1 | Accumulator write enable |
| skip | output | 1 | Skip next instruction |
| kbd_valid | input | 1 | Keyboard code offered |
| kbd_data | input | 8 | Keyboard code |
| kbd_ready | output | 1 | Keyboard code can be taken |
| kbd_req | output | 1 | Request next keyboard code |
| prn_start | output | 1 | Start printing `prn_char` |
| prn_char | output | 8 | Printer holding register |
| prn_done | input | 1 | Printer finished a character |
| intr_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a collision inside one cycle. Examples are a skip-and-clear instruction that must test the old ready bit, a printer completion that coincides with a clear, and a keyboard code that arrives in the same cycle as a clear. From the ports, the bench has to set up the ready bit first and then drive both events in the same half-cycle window. It then reads the surviving state back through a later skip instruction and the interrupt line, because neither ready bit is a port.

// File: rtl/iot_tty_pkg.sv
package iot_tty_pkg;
  localparam int WORD_W = 12;
  localparam int CHAR_W = 8;
  localparam int DEV_W  = 6;
  localparam int FN_W   = 3;
  localparam int OPC_W  = 3;

  // function mask bit positions
  localparam int FN_SKIP_BIT = 0;
  localparam int FN_CLR_BIT  = 1;
  localparam int FN_XFER_BIT = 2;

  typedef struct packed {
    logic zero;  // whole mask is 0
    logic xfer;
    logic clr;
    logic skip;
  } fn_req_t;
endpackage

// File: rtl/iot_decode.sv
module iot_decode
  import iot_tty_pkg::*;
#(
  parameter int             W_WORD  = WORD_W,
  parameter logic [2:0]     OPCODE  = 3'o6,
  parameter int             NDEV    = 2,
  parameter logic [NDEV*DEV_W-1:0] DEV_IDS = {6'o04, 6'o03}
) (
  input  logic            iot_valid,
  input  logic [W_WORD-1:0] instr,
  output logic [NDEV-1:0] dev_sel,
  output fn_req_t         fn
);
  localparam int FN_LSB  = 0;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int OPC_LSB = DEV_LSB + DEV_W;

  logic             is_iot;
  logic [DEV_W-1:0] dev_f;
  logic [FN_W-1:0]  fn_f;

  assign is_iot = iot_valid && (instr[OPC_LSB +: OPC_W] == OPCODE);
  assign dev_f  = instr[DEV_LSB +: DEV_W];
  assign fn_f   = instr[FN_LSB +: FN_W];

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign dev_sel[d] = is_iot && (dev_f == DEV_IDS[d*DEV_W +: DEV_W]);
  end

  assign fn.skip = fn_f[FN_SKIP_BIT];
  assign fn.clr  = fn_f[FN_CLR_BIT];
  assign fn.xfer = fn_f[FN_XFER_BIT];
  assign fn.zero = (fn_f == '0);
endmodule

// File: rtl/iot_kbd_unit.sv
module iot_kbd_unit
  import iot_tty_pkg::*;
#(
  parameter int W_WORD = WORD_W,
  parameter int W_CHAR = CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  fn_req_t           fn,
  input  logic [W_WORD-1:0] ac_in,
  input  logic              kbd_valid,
  input  logic [W_CHAR-1:0] kbd_data,
  output logic              kbd_ready,
  output logic              flag,
  output logic [W_CHAR-1:0] char_q,
  output logic              skip,
  output logic              ac_we,
  output logic [W_WORD-1:0] ac_out,
  output logic              req
);
  localparam int PAD_W = W_WORD - W_CHAR;

  logic take, clr_now;
  logic [W_WORD-1:0] base;

  assign kbd_ready = !flag;
  assign take      = kbd_valid && !flag;
  assign clr_now   = sel && (fn.zero || fn.clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      char_q <= '0;
    end else if (take) begin
      flag   <= 1'b1;
      char_q <= kbd_data;
    end else if (clr_now) begin
      flag   <= 1'b0;
    end
  end

  assign skip  = sel && fn.skip && flag;
  assign ac_we = sel && (fn.clr || fn.xfer);
  assign req   = sel && fn.clr;

  always_comb begin
    base = (sel && fn.clr) ? '0 : ac_in;
    if (sel && fn.xfer) ac_out = base | {{PAD_W{1'b0}}, char_q};
    else                ac_out = base;
  end
endmodule

// File: rtl/iot_prn_unit.sv
module iot_prn_unit
  import iot_tty_pkg::*;
#(
  parameter int W_CHAR = CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              fn_skip,
  input  logic              fn_clr,
  input  logic              fn_xfer,
  input  logic [W_CHAR-1:0] ac_lo,
  input  logic              prn_done,
  output logic              flag,
  output logic              prn_start,
  output logic [W_CHAR-1:0] prn_char,
  output logic              skip
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      prn_start <= 1'b0;
      prn_char  <= '0;
    end else begin
      if (prn_done)           flag <= 1'b1;
      else if (sel && fn_clr) flag <= 1'b0;
      prn_start <= sel && fn_xfer;
      if (sel && fn_xfer) prn_char <= ac_lo;
    end
  end

  assign skip = sel && fn_skip && flag;
endmodule

// File: rtl/iot_tty_ctrl.sv
module iot_tty_ctrl
  import iot_tty_pkg::*;
#(
  parameter int          W_WORD  = WORD_W,
  parameter int          W_CHAR  = CHAR_W,
  parameter logic [5:0]  KBD_DEV = 6'o03,
  parameter logic [5:0]  PRN_DEV = 6'o04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_valid,
  input  logic [W_WORD-1:0] instr,
  input  logic [W_WORD-1:0] ac_in,
  output logic [W_WORD-1:0] ac_out,
  output logic              ac_we,
  output logic              skip,
  input  logic              kbd_valid,
  input  logic [W_CHAR-1:0] kbd_data,
  output logic              kbd_ready,
  output logic              kbd_req,
  output logic              prn_start,
  output logic [W_CHAR-1:0] prn_char,
  input  logic              prn_done,
  input  logic              intr_en,
  output logic              irq
);
  localparam int KBD_IDX = 0;
  localparam int PRN_IDX = 1;
  localparam int NDEV    = 2;

  logic [NDEV-1:0]   dev_sel;
  fn_req_t           fn;
  logic              kbd_flag, prn_flag;
  logic              kbd_skip, prn_skip;
  logic [W_CHAR-1:0] kbd_char;

  iot_decode #(
    .W_WORD (W_WORD),
    .OPCODE (3'o6),
    .NDEV   (NDEV),
    .DEV_IDS({PRN_DEV, KBD_DEV})
  ) u_dec (
    .iot_valid(iot_valid),
    .instr    (instr),
    .dev_sel  (dev_sel),
    .fn       (fn)
  );

  iot_kbd_unit #(.W_WORD(W_WORD), .W_CHAR(W_CHAR)) u_kbd (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (dev_sel[KBD_IDX]),
    .fn       (fn),
    .ac_in    (ac_in),
    .kbd_valid(kbd_valid),
    .kbd_data (kbd_data),
    .kbd_ready(kbd_ready),
    .flag     (kbd_flag),
    .char_q   (kbd_char),
    .skip     (kbd_skip),
    .ac_we    (ac_we),
    .ac_out   (ac_out),
    .req      (kbd_req)
  );

  iot_prn_unit #(.W_CHAR(W_CHAR)) u_prn (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (dev_sel[PRN_IDX]),
    .fn_skip  (fn.skip),
    .fn_clr   (fn.clr),
    .fn_xfer  (fn.xfer),
    .ac_lo    (ac_in[W_CHAR-1:0]),
    .prn_done (prn_done),
    .flag     (prn_flag),
    .prn_start(prn_start),
    .prn_char (prn_char),
    .skip     (prn_skip)
  );

  assign skip = kbd_skip || prn_skip;
  assign irq  = intr_en && (kbd_flag || prn_flag);
endmodule

// File: rtl/iot_tty_ctrl_chk.sv
module iot_tty_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iot_valid,
  input logic [11:0] instr,
  input logic [11:0] ac_in,
  input logic        ac_we,
  input logic        skip,
  input logic        kbd_valid,
  input logic        kbd_ready,
  input logic [7:0]  kbd_data,
  input logic        kbd_flag,
  input logic [7:0]  kbd_char,
  input logic        prn_start,
  input logic [7:0]  prn_char,
  input logic        prn_done,
  input logic        prn_flag,
  input logic        intr_en,
  input logic        irq
);
  // R2
  ac_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ac_we |-> (iot_valid && instr[11:9] == 3'o6));
  // R3
  skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (iot_valid && instr[0]));
  // R7
  kbd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_valid && kbd_ready) |=> (kbd_flag && kbd_char == $past(kbd_data)));
  // R7
  kbd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_valid && !kbd_ready) |=> $stable(kbd_char));
  // R8
  prn_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && instr[11:9] == 3'o6 && instr[8:3] == 6'o04 && instr[2])
      |=> (prn_start && prn_char == $past(ac_in[7:0])));
  // R9
  prn_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prn_done |=> prn_flag);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_en |-> !irq);
endmodule

bind iot_tty_ctrl iot_tty_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iot_valid(iot_valid),
  .instr    (instr),
  .ac_in    (ac_in),
  .ac_we    (ac_we),
  .skip     (skip),
  .kbd_valid(kbd_valid),
  .kbd_ready(kbd_ready),
  .kbd_data (kbd_data),
  .kbd_flag (kbd_flag),
  .kbd_char (kbd_char),
  .prn_start(prn_start),
  .prn_char (prn_char),
  .prn_done (prn_done),
  .prn_flag (prn_flag),
  .intr_en  (intr_en),
  .irq      (irq)
);

// File: tb/test_iot_tty_ctrl.sv
module test_iot_tty_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        iot_valid = 0;
  logic [11:0] instr = '0;
  logic [11:0] ac_in = '0;
  logic [11:0] ac_out;
  logic        ac_we, skip;
  logic        kbd_valid = 0;
  logic [7:0]  kbd_data = '0;
  logic        kbd_ready, kbd_req;
  logic        prn_start;
  logic [7:0]  prn_char;
  logic        prn_done = 0;
  logic        intr_en = 0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [5:0] KBD = 6'o03;
  localparam logic [5:0] PRN = 6'o04;

  always #5 clk = ~clk;

  iot_tty_ctrl i_iot_tty_ctrl (
    .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .instr(instr),
    .ac_in(ac_in), .ac_out(ac_out), .ac_we(ac_we), .skip(skip),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .kbd_ready(kbd_ready),
    .kbd_req(kbd_req), .prn_start(prn_start), .prn_char(prn_char),
    .prn_done(prn_done), .intr_en(intr_en), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one instruction word for one cycle; capture same-cycle outputs
  typedef struct { logic sk; logic we; logic rq; logic [11:0] ao; } resp_t;
  resp_t r;

  task automatic raw(input logic v, input logic [11:0] w, input logic [11:0] ac);
    @(negedge clk);
    iot_valid = v; instr = w; ac_in = ac;
    #1;
    r.sk = skip; r.we = ac_we; r.rq = kbd_req; r.ao = ac_out;
    @(negedge clk);
    iot_valid = 0; instr = '0; ac_in = '0;
    #1;
  endtask

  task automatic iot(input logic [5:0] dev, input logic [2:0] fn, input logic [11:0] ac);
    raw(1'b1, {3'o6, dev, fn}, ac);
  endtask

  task automatic kbd_send(input logic [7:0] c);
    @(negedge clk);
    kbd_valid = 1; kbd_data = c;
    @(negedge clk);
    kbd_valid = 0;
    #1;
  endtask

  task automatic flag_is(input string req, input logic [5:0] dev, input logic exp);
    iot(dev, 3'o1, 12'o0);
    chk(req, r.sk, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 kbd_ready", kbd_ready, 1);
    chk("R1 prn_start", prn_start, 0);
    chk("R1 ac_we", ac_we, 0);
    flag_is("R1 kbd flag", KBD, 0);
    flag_is("R1 prn flag", PRN, 0);
  endtask

  task automatic t_kbd_capture;
    kbd_send(8'h41);
    chk("R7 ready low", kbd_ready, 0);
    flag_is("R7 kbd flag set", KBD, 1);
    kbd_send(8'h42);  // dropped
    iot(KBD, 3'o4, 12'h700);
    chk("R6 read we", r.we, 1);
    chk("R7 held char / R6 OR", r.ao, 12'h741);
    chk("R6 no req", r.rq, 0);
  endtask

  task automatic t_kbd_fn6;
    iot(KBD, 3'o6, 12'hFFF);
    chk("R6 clear then read", r.ao, 12'h041);
    chk("R5 req", r.rq, 1);
    flag_is("R5 flag cleared", KBD, 0);
  endtask

  task automatic t_kbd_fn2_fn0;
    kbd_send(8'h10);
    iot(KBD, 3'o2, 12'h123);
    chk("R5 ac cleared", r.ao, 0);
    chk("R5 we", r.we, 1);
    chk("R5 req", r.rq, 1);
    flag_is("R5 flag cleared", KBD, 0);
    kbd_send(8'h11);
    iot(KBD, 3'o0, 12'h123);
    chk("R4 no we", r.we, 0);
    chk("R4 no req", r.rq, 0);
    flag_is("R4 flag cleared", KBD, 0);
  endtask

  task automatic t_skip_before_clear;
    kbd_send(8'h20);
    iot(KBD, 3'o3, 12'h0);
    chk("R3 skip old flag", r.sk, 1);
    flag_is("R3 flag cleared after", KBD, 0);
  endtask

  task automatic t_set_wins;
    // flag is 0: code arrives in the same cycle as a function-0 clear
    @(negedge clk);
    kbd_valid = 1; kbd_data = 8'h55;
    iot_valid = 1; instr = {3'o6, KBD, 3'o0};
    @(negedge clk);
    kbd_valid = 0; iot_valid = 0; instr = '0;
    #1;
    flag_is("R7 set wins", KBD, 1);
    iot(KBD, 3'o6, 12'h0);
    chk("R7 char latched", r.ao, 12'h055);
  endtask

  task automatic t_decode;
    kbd_send(8'h66);
    raw(1'b1, {3'o5, KBD, 3'o6}, 12'hABC);
    chk("R2 wrong opcode we", r.we, 0);
    chk("R2 wrong opcode req", r.rq, 0);
    raw(1'b1, {3'o6, 6'o05, 3'o7}, 12'hABC);
    chk("R2 wrong dev we", r.we, 0);
    chk("R2 wrong dev skip", r.sk, 0);
    raw(1'b0, {3'o6, KBD, 3'o7}, 12'hABC);
    chk("R2 not valid we", r.we, 0);
    flag_is("R2 flag kept", KBD, 1);
    iot(KBD, 3'o6, 12'h0);
    chk("R2 char kept", r.ao, 12'h066);
  endtask

  task automatic t_prn;
    iot(PRN, 3'o4, 12'hA5C);
    chk("R8 start", prn_start, 1);
    chk("R8 char", prn_char, 8'h5C);
    chk("R9 no we", r.we, 0);
    @(negedge clk); #1;
    chk("R8 one pulse", prn_start, 0);
    flag_is("R8 flag unchanged", PRN, 0);
    @(negedge clk); prn_done = 1;
    @(negedge clk); prn_done = 0; #1;
    flag_is("R9 done sets", PRN, 1);
    iot(PRN, 3'o6, 12'h03D);
    chk("R8 fn6 start", prn_start, 1);
    chk("R8 fn6 char", prn_char, 8'h3D);
    flag_is("R9 fn6 clears", PRN, 0);
    @(negedge clk);
    prn_done = 1; iot_valid = 1; instr = {3'o6, PRN, 3'o2};
    @(negedge clk);
    prn_done = 0; iot_valid = 0; instr = '0;
    #1;
    flag_is("R9 done wins", PRN, 1);
  endtask

  task automatic t_irq;
    // printer flag set, keyboard flag clear here
    iot(KBD, 3'o0, 12'h0);
    intr_en = 0; #1;
    chk("R10 disabled", irq, 0);
    intr_en = 1; #1;
    chk("R10 prn flag", irq, 1);
    iot(PRN, 3'o2, 12'h0);
    chk("R10 none set", irq, 0);
    kbd_send(8'h01);
    chk("R10 kbd flag", irq, 1);
    intr_en = 0;
  endtask

  initial begin
    #500us;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_kbd_capture();
    t_kbd_fn6();
    t_kbd_fn2_fn0();
    t_skip_before_clear();
    t_set_wins();
    t_decode();
    t_prn();
    t_irq();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule